// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block runs a single read or write access on one external static memory chip select. A start pulse with a direction bit begins the access. The block then counts down the programmed number of wait states for that direction. While the countdown runs it holds the active-low chip select low, and it also holds either the output enable or the write enable low.

The slave can stretch the access by pulling an active-low wait input low. The pin first passes through a two-flop synchroniser. The sequencer honours it only inside a sampling window near the end of the countdown. Once the wait is released, a fixed tail of cycles runs before the strobes end. A stall that never ends is cut off by a saturating counter, which raises a timeout flag and finishes the access anyway.

Completion is reported to the requesting bus side as a single-cycle done pulse.

Top module: `smc_wait_seq`

## Requirements
- R1: After reset, cs_no, oe_no and we_no are high, and done_o and timeout_o are low.
- R2: With no wait, cs_no stays low for N+1 cycles. These are the countdown steps N..1 plus one final cycle. N is rd_wst_i for reads and wr_wst_i for writes, captured at start.
- R3: A programmed count below 3 is treated as 3, so the shortest access holds cs_no low for 4 cycles.
- R4: On a read (write_i=0), oe_no is low in every cycle that cs_no is low, and we_no stays high.
- R5: On a write (write_i=1), we_no falls in the same cycle as cs_no and rises one cycle before cs_no rises. oe_no stays high.
- R6: A synchronised wait low that is seen only while the countdown value is above 3 adds no cycles.
- R7: A synchronised wait low that is seen while the countdown value is 3, 2 or 1 inserts stall cycles after step 1. The stall lasts until the synchronised wait is seen high. Then 5 tail cycles and the final cycle follow. The synchroniser delays the pin by 2 cycles.
- R8: done_o is high for exactly one cycle, which is the first cycle after cs_no returns high.
- R9: If a stall reaches 16383 cycles, the access completes through the tail. timeout_o is then high from that point until the next accepted start.
- R10: A start_i pulse during an access is ignored. No second access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| write_i | input | 1 | Direction of the access, 1 = write |
| rd_wst_i | input | WST_W | Read wait-state count |
| wr_wst_i | input | WST_W | Write wait-state count |
| wait_ni | input | 1 | Asynchronous active-low wait from the slave |
| cs_no | output | 1 | Active-low chip select |
| oe_no | output | 1 | Active-low output enable |
| we_no | output | 1 | Active-low write enable |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Stall limit reached during the last access |

## Verification
The hardest case to reach is a wait assertion whose synchronised copy crosses the edge of the sampling window. One cycle earlier it is ignored; one cycle later it stalls the access. The stimulus places the wait pulse at each offset relative to the first chip-select cycle, accounting for the two synchroniser cycles. The bench model replays the countdown to predict the exact chip-select length. Random offsets and lengths, run against both small and large counts, cover the boundary from both sides. One directed run holds the wait low past the stall limit to reach the timeout.

// File: rtl/smc_wait_pkg.sv
package smc_wait_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_STALL,
    ST_TAIL,
    ST_LAST
  } seq_state_e;
endpackage

// File: rtl/smc_wait_sync.sv
module smc_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/smc_wait_fsm.sv
module smc_wait_fsm
  import smc_wait_pkg::*;
#(
  parameter int WST_W       = 4,
  parameter int MIN_WST     = 3,
  parameter int WIN_OPEN    = 3,
  parameter int TAIL_CYC    = 5,
  parameter int STALL_LIMIT = 16383
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [WST_W-1:0] rd_wst_i,
  input  logic [WST_W-1:0] wr_wst_i,
  input  logic             wait_act_i,
  output logic             cs_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int STALL_W = $clog2(STALL_LIMIT + 1);
  localparam int TAIL_W  = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
  localparam logic [WST_W-1:0]   MIN_V   = WST_W'(MIN_WST);
  localparam logic [WST_W-1:0]   WIN_V   = WST_W'(WIN_OPEN);
  localparam logic [STALL_W-1:0] STALL_V = STALL_W'(STALL_LIMIT - 1);
  localparam logic [TAIL_W-1:0]  TAIL_V  = TAIL_W'(TAIL_CYC - 1);

  seq_state_e         state_q;
  logic [WST_W-1:0]   cnt_q;
  logic [STALL_W-1:0] stall_q;
  logic [TAIL_W-1:0]  tail_q;
  logic               arm_q, write_q, to_q, done_q;

  logic [WST_W-1:0] n_raw, n_eff;
  logic             in_win, arm_now;

  assign n_raw   = write_i ? wr_wst_i : rd_wst_i;
  assign n_eff   = (n_raw < MIN_V) ? MIN_V : n_raw;
  assign in_win  = (cnt_q <= WIN_V);
  assign arm_now = arm_q | (in_win & wait_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      stall_q <= '0;
      tail_q  <= '0;
      arm_q   <= 1'b0;
      write_q <= 1'b0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_LAST);
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          write_q <= write_i;
          cnt_q   <= n_eff;
          arm_q   <= 1'b0;
          stall_q <= '0;
          to_q    <= 1'b0;
          state_q <= ST_COUNT;
        end
        ST_COUNT: begin
          arm_q <= arm_now;
          if (cnt_q == WST_W'(1)) state_q <= arm_now ? ST_STALL : ST_LAST;
          else                    cnt_q   <= cnt_q - 1'b1;
        end
        ST_STALL: begin
          if (!wait_act_i) begin
            tail_q  <= TAIL_V;
            state_q <= ST_TAIL;
          end else if (stall_q == STALL_V) begin
            to_q    <= 1'b1;
            tail_q  <= TAIL_V;
            state_q <= ST_TAIL;
          end else begin
            stall_q <= stall_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_q == '0) state_q <= ST_LAST;
          else              tail_q  <= tail_q - 1'b1;
        end
        ST_LAST: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = (state_q == ST_IDLE);
  assign oe_no     = (state_q == ST_IDLE) | write_q;
  assign we_no     = (state_q == ST_IDLE) | ~write_q | (state_q == ST_LAST);
  assign done_o    = done_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/smc_wait_seq.sv
module smc_wait_seq #(
  parameter int WST_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TAIL_CYC    = 5,
  parameter int STALL_LIMIT = 16383
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [WST_W-1:0] rd_wst_i,
  input  logic [WST_W-1:0] wr_wst_i,
  input  logic             wait_ni,
  output logic             cs_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             done_o,
  output logic             timeout_o
);
  logic wait_sync_n;

  smc_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wait_ni),
    .q_o   (wait_sync_n)
  );

  smc_wait_fsm #(
    .WST_W      (WST_W),
    .MIN_WST    (3),
    .WIN_OPEN   (3),
    .TAIL_CYC   (TAIL_CYC),
    .STALL_LIMIT(STALL_LIMIT)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .write_i   (write_i),
    .rd_wst_i  (rd_wst_i),
    .wr_wst_i  (wr_wst_i),
    .wait_act_i(~wait_sync_n),
    .cs_no     (cs_no),
    .oe_no     (oe_no),
    .we_no     (we_no),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );
endmodule

// File: rtl/smc_wait_seq_chk.sv
module smc_wait_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic oe_no,
  input logic we_no,
  input logic done_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no)); // R4

  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_no || !we_no) |-> !cs_no); // R5

  AST_WE_ENDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !we_no) |=> (!we_no || we_no && !cs_no)); // R5

  AST_LAST_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(we_no)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |=> !cs_no); // R3
endmodule

bind smc_wait_seq smc_wait_seq_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cs_no (cs_no),
  .oe_no (oe_no),
  .we_no (we_no),
  .done_o(done_o)
);

// File: tb/test_smc_wait_seq.sv
module test_smc_wait_seq;
  localparam int WST_W = 4;
  localparam int LIMIT = 16383;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0, wait_ni = 1'b1;
  logic [WST_W-1:0] rd_wst_i = '0, wr_wst_i = '0;
  logic cs_no, oe_no, we_no, done_o, timeout_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  smc_wait_seq i_smc_wait_seq (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin value during access cycle c (cycle 0 = first chip-select cycle)
  function automatic bit pin_at(int c, int a, int l);
    return !(c >= a && c < a + l);
  endfunction

  // Expected chip-select length and timeout, from the requirements
  function automatic int exp_len(int n, int a, int l, output bit to);
    int k = (n < 3) ? 3 : n;
    int st = 0, sc = 0, tc = 0;
    bit arm = 0;
    to = 0;
    for (int c = 0; c < 40000; c++) begin
      bit s = (c < 2) ? 1'b1 : pin_at(c - 2, a, l);
      case (st)
        0: begin
          if (k <= 3 && !s) arm = 1;
          if (k == 1) st = arm ? 1 : 3;
          else k--;
        end
        1: begin
          if (s) begin st = 2; tc = 4; end
          else if (sc == LIMIT - 1) begin to = 1; st = 2; tc = 4; end
          else sc++;
        end
        2: if (tc == 0) st = 3; else tc--;
        default: return c + 1;
      endcase
    end
    return -1;
  endfunction

  task automatic run_access(input bit wr, input int nrd, input int nwr,
                            input int a, input int l, input bit poke, input string req);
    int n = wr ? nwr : nrd;
    int exp, cs_len = 0, we_len = 0, oe_len = 0, we_first = -1, we_last = -1;
    bit exp_to, done_ok = 0;
    exp = exp_len(n, a, l, exp_to);
    @(negedge clk_i);
    start_i = 1'b1; write_i = wr;
    rd_wst_i = WST_W'(nrd); wr_wst_i = WST_W'(nwr);
    wait_ni = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 40000; c++) begin
      wait_ni = pin_at(c, a, l);
      if (poke) start_i = (c == 2);
      if (cs_no) begin
        done_ok = done_o;
        break;
      end
      cs_len++;
      if (!we_no) begin
        we_len++;
        if (we_first < 0) we_first = c;
        we_last = c;
      end
      if (!oe_no) oe_len++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    wait_ni = 1'b1;
    check(cs_len == exp, req, cs_len, exp);
    if (wr) begin
      check(we_first == 0 && we_len == exp - 1 && we_last == exp - 2, "R5 we window", we_len, exp - 1);
      check(oe_len == 0, "R5 oe idle", oe_len, 0);
    end else begin
      check(oe_len == exp && we_len == 0, "R4 read strobes", oe_len, exp);
    end
    check(done_ok, "R8 done", done_ok, 1);
    check(timeout_o == exp_to, "R9 timeout flag", timeout_o, exp_to);
    @(negedge clk_i);
    check(!done_o, "R8 single", done_o, 0);
    if (poke) begin
      for (int i = 0; i < 4; i++) begin
        check(cs_no, "R10 start ignored", cs_no, 1);
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(cs_no && oe_no && we_no && !done_o && !timeout_o, "R1 reset", {cs_no, oe_no, we_no}, 7);
    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    check(cs_no && !done_o && !timeout_o, "R1 after release", cs_no, 1);

    run_access(0, 6, 3, 100, 0, 0, "R2 read no wait");
    run_access(1, 2, 9, 100, 0, 0, "R2 write no wait");
    run_access(1, 7, 0, 100, 0, 0, "R3 write clamp");
    run_access(0, 1, 5, 100, 0, 0, "R3 read clamp");
    run_access(0, 8, 3, 0, 3, 0, "R6 early wait ignored");
    run_access(1, 3, 8, 1, 2, 0, "R6 wait ends before window");
    run_access(0, 5, 3, 0, 2, 0, "R7 wait at window edge");
    run_access(1, 3, 5, 1, 2, 0, "R7 write stall");
    run_access(0, 3, 3, 0, 12, 0, "R7 long stall");
    run_access(1, 3, 6, 4, 1, 0, "R7 late short wait");
    run_access(0, 4, 3, 2, 6, 1, "R10 busy start");
    for (int i = 0; i < 30; i++) begin
      bit w = $urandom_range(1, 0);
      int nr = $urandom_range(12, 0);
      int nw = $urandom_range(12, 0);
      int a = $urandom_range(14, 0);
      int l = $urandom_range(20, 0);
      run_access(w, nr, nw, a, l, 0, "R7 random");
    end
    run_access(1, 3, 3, 0, 17000, 0, "R9 stall limit");
    run_access(0, 4, 3, 100, 0, 0, "R9 flag cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule